// File: doc/BRIEF.md
# Fractional-Increment Precision Time Counter

This block keeps a free-running time of day made of a nanoseconds count and a 48-bit seconds count. On every clock edge it adds a programmable step to that time. The step is a fixed-point nanosecond value with 20 fraction bits. The fraction left over after each step is kept and carries into the nanoseconds on later edges, so a clock period that is not a whole number of nanoseconds still gives the correct long-term rate. When the nanoseconds reach a programmable wrap value, they carry into the seconds.

The host never reads the running time directly. It writes a one-shot command into a 2-bit request field: either take a snapshot into three capture registers, or zero the time. The field reads back as idle once the command has been carried out.

New time values and new step values are first written to shadow registers. They are then committed by raising a load flag. Each flag stays set, and is reported as busy, until the hardware has applied the value. It then clears itself without any further host action.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time, the fraction and the capture registers are zero, the request field reads 0, both busy outputs are low, and the active step equals the `DEF_INC` parameter.
- R2: Each edge without a load or zeroing adds the active step to the time. The fraction bits `inc[19:0]` accumulate modulo 2^20, and each overflow adds 1 ns on top of the integer part `inc >> 20`. After k steps from a zero fraction, the nanoseconds have advanced by floor(k*step / 2^20).
- R3: The nanoseconds stay below `NS_WRAP`. Passing `NS_WRAP` subtracts `NS_WRAP` and adds one second. The seconds wrap from 2^48-1 to 0.
- R4: The request codes are 0 = idle, 1 = zero the time and 2 = capture. A write is accepted only while the field reads 0, and code 3 is ignored. An accepted code is shown for exactly one cycle, and the field returns to 0 on the next edge.
- R5: A capture copies the time present in the cycle the capture code is shown into `cap_ns`, `cap_sec_lo` (seconds bits 31:0) and `cap_sec_hi` (seconds bits 47:32). At all other times these registers hold their value.
- R6: A zeroing command clears the nanoseconds, the seconds and the fraction on the edge that completes it. That edge performs no step.
- R7: Raising `ofs_load` sets `ofs_busy`. On the next edge the time is replaced by the shadow value, with the fraction cleared and the nanoseconds clamped to `NS_WRAP-1`. `ofs_busy` clears one edge later. A raise while busy is ignored.
- R8: `inc_load` follows the same set, transfer and clear sequence with `inc_busy`. The step performed on the transfer edge still uses the old increment.
- R9: When an offset transfer and a zeroing command complete on the same edge, the offset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write strobe for the request field |
| req_code | input | 2 | Request code: 1 = zero the time, 2 = capture |
| req_state | output | 2 | Request field readback, 0 when idle |
| ofs_wr | input | 1 | Write strobe for the time shadow |
| ofs_ns | input | 32 | Shadow nanoseconds |
| ofs_sec_lo | input | 32 | Shadow seconds bits 31:0 |
| ofs_sec_hi | input | 16 | Shadow seconds bits 47:32 |
| ofs_load | input | 1 | Raise to commit the time shadow |
| ofs_busy | output | 1 | Time load flag still set |
| inc_wr | input | 1 | Write strobe for the step shadow |
| inc_val | input | INC_W | Shadow step, 20 fraction bits |
| inc_load | input | 1 | Raise to commit the step shadow |
| inc_busy | output | 1 | Step load flag still set |
| cap_ns | output | 32 | Captured nanoseconds |
| cap_sec_lo | output | 32 | Captured seconds bits 31:0 |
| cap_sec_hi | output | 16 | Captured seconds bits 47:32 |

## Verification
The embedded assertions check the following on every cycle:
- the nanoseconds stay inside their range;
- the seconds never move by more than one between loads;
- a request is shown for a single cycle, and the reserved code never appears in the field;
- each load flag follows its transfer-then-clear sequence;
- the capture registers and the active step change only on their own events.

Only the bench scenarios can show that the arithmetic gives the right values. They sweep several step values, including fractional ones, over many step counts, and they load preset times at the nanosecond and seconds wrap points. They also show the ordering effects: that the old step is still used on a step-transfer edge, that an offset wins over a zeroing command on the same edge, and that a request arriving while the field is busy is dropped.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int REG_W    = 32;
  localparam int SEC_HI_W = 16;
  localparam int SEC_W    = REG_W + SEC_HI_W;

  typedef enum logic [1:0] {
    REQ_IDLE    = 2'd0,
    REQ_ZERO    = 2'd1,
    REQ_CAPTURE = 2'd2,
    REQ_RSVD    = 2'd3
  } req_code_e;

endpackage

// File: rtl/ptp_req_ctrl.sv
module ptp_req_ctrl
  import ptp_tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic [1:0] req_code,
  output logic [1:0] req_state,
  output logic       cap_fire,
  output logic       zero_fire
);

  req_code_e req_q;
  req_code_e code_in;
  logic      accept;

  assign code_in = req_code_e'(req_code);
  assign accept  = req_wr && (req_q == REQ_IDLE) &&
                   ((code_in == REQ_ZERO) || (code_in == REQ_CAPTURE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= REQ_IDLE;
    end else if (req_q != REQ_IDLE) begin
      req_q <= REQ_IDLE;
    end else if (accept) begin
      req_q <= code_in;
    end
  end

  assign req_state = req_q;
  assign cap_fire  = (req_q == REQ_CAPTURE);
  assign zero_fire = (req_q == REQ_ZERO);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != REQ_IDLE) |=> (req_q == REQ_IDLE)); // R4
  AST_REQ_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != REQ_RSVD)); // R4
  AST_REQ_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != REQ_IDLE && req_wr) |=> (req_q == REQ_IDLE)); // R4

endmodule

// File: rtl/ptp_load_hs.sv
module ptp_load_hs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          set_i,
  output logic [DW-1:0] shadow_o,
  output logic          xfer_o,
  output logic          busy_o
);

  logic [DW-1:0] shadow_q;
  logic          pending_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr_i) begin
      shadow_q <= data_i;
    end
  end

  // Flag set -> one transfer edge -> flag clears on the following edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (done_q) begin
      pending_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (pending_q) begin
      done_q    <= 1'b1;
    end else if (set_i) begin
      pending_q <= 1'b1;
    end
  end

  assign shadow_o = shadow_q;
  assign xfer_o   = pending_q && !done_q;
  assign busy_o   = pending_q;

  AST_LOAD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && set_i) |=> xfer_o); // R7, R8
  AST_LOAD_XFER_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |=> (busy_o && !xfer_o)); // R7, R8
  AST_LOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !xfer_o) |=> !busy_o); // R7, R8

endmodule

// File: rtl/ptp_time_acc.sv
module ptp_time_acc
  import ptp_tc_pkg::*;
#(
  parameter int                 NS_WRAP = 1000000000,
  parameter int                 INC_W   = 32,
  parameter int                 FRAC_W  = 20,
  parameter logic [INC_W-1:0]   DEF_INC = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_ns,
  input  logic [SEC_W-1:0] load_sec,
  input  logic             inc_xfer_i,
  input  logic [INC_W-1:0] inc_new,
  output logic [REG_W-1:0] ns_o,
  output logic [SEC_W-1:0] sec_o
);

  localparam int NS_W  = $clog2(NS_WRAP);
  localparam int INT_W = INC_W - FRAC_W;
  localparam int SUM_W = ((NS_W > INT_W) ? NS_W : INT_W) + 2;
  localparam logic [SUM_W-1:0] WRAP_S  = SUM_W'(NS_WRAP);
  localparam logic [REG_W-1:0] WRAP_R  = REG_W'(NS_WRAP);
  localparam logic [NS_W-1:0]  NS_MAX  = NS_W'(NS_WRAP - 1);

  logic [INC_W-1:0]  incr_q;
  logic [FRAC_W-1:0] frac_q;
  logic [NS_W-1:0]   ns_q;
  logic [SEC_W-1:0]  sec_q;

  // Fraction sum with carry in the top bit.
  function automatic logic [FRAC_W:0] frac_add(input logic [FRAC_W-1:0] f,
                                               input logic [INC_W-1:0]  inc);
    return {1'b0, f} + {1'b0, inc[FRAC_W-1:0]};
  endfunction

  // Whole-nanosecond advance: integer part of the step plus fraction carry.
  function automatic logic [SUM_W-1:0] int_step(input logic [INC_W-1:0] inc,
                                                input logic             carry);
    return SUM_W'(inc[INC_W-1:FRAC_W]) + SUM_W'(carry);
  endfunction

  // Nanosecond advance with wrap flag in the top bit.
  function automatic logic [NS_W:0] ns_advance(input logic [NS_W-1:0]  ns,
                                               input logic [SUM_W-1:0] step);
    logic [SUM_W-1:0] sum;
    sum = SUM_W'(ns) + step;
    if (sum >= WRAP_S) return {1'b1, NS_W'(sum - WRAP_S)};
    else               return {1'b0, NS_W'(sum)};
  endfunction

  function automatic logic [NS_W-1:0] ns_clamp(input logic [REG_W-1:0] v);
    if (v >= WRAP_R) return NS_MAX;
    else             return NS_W'(v);
  endfunction

  logic [FRAC_W:0]  frac_sum;
  logic [SUM_W-1:0] step_ns;
  logic [NS_W:0]    ns_res;
  logic             sec_carry;

  assign frac_sum  = frac_add(frac_q, incr_q);
  assign step_ns   = int_step(incr_q, frac_sum[FRAC_W]);
  assign ns_res    = ns_advance(ns_q, step_ns);
  assign sec_carry = ns_res[NS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      incr_q <= DEF_INC;
    end else if (inc_xfer_i) begin
      incr_q <= inc_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac_q <= '0;
      ns_q   <= '0;
      sec_q  <= '0;
    end else if (load_i) begin
      frac_q <= '0;
      ns_q   <= ns_clamp(load_ns);
      sec_q  <= load_sec;
    end else if (clear_i) begin
      frac_q <= '0;
      ns_q   <= '0;
      sec_q  <= '0;
    end else begin
      frac_q <= frac_sum[FRAC_W-1:0];
      ns_q   <= ns_res[NS_W-1:0];
      sec_q  <= sec_q + SEC_W'(sec_carry);
    end
  end

  assign ns_o  = REG_W'(ns_q);
  assign sec_o = sec_q;

  AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_o < WRAP_R)); // R3
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clear_i) |=>
      ((sec_q == $past(sec_q)) || (sec_q == SEC_W'($past(sec_q) + 1'b1)))); // R3
  AST_ZERO_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !load_i) |=> (ns_o == '0 && sec_o == '0)); // R6
  AST_LOAD_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sec_o == $past(load_sec))); // R7, R9
  AST_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_xfer_i |=> $stable(incr_q)); // R8

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int               NS_WRAP = 1000000000,
  parameter int               INC_W   = 32,
  parameter int               FRAC_W  = 20,
  parameter logic [INC_W-1:0] DEF_INC = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [1:0]       req_code,
  output logic [1:0]       req_state,
  input  logic             ofs_wr,
  input  logic [31:0]      ofs_ns,
  input  logic [31:0]      ofs_sec_lo,
  input  logic [15:0]      ofs_sec_hi,
  input  logic             ofs_load,
  output logic             ofs_busy,
  input  logic             inc_wr,
  input  logic [INC_W-1:0] inc_val,
  input  logic             inc_load,
  output logic             inc_busy,
  output logic [31:0]      cap_ns,
  output logic [31:0]      cap_sec_lo,
  output logic [15:0]      cap_sec_hi
);

  localparam int OFS_W = REG_W + SEC_W;

  logic             cap_fire;
  logic             zero_fire;
  logic [OFS_W-1:0] ofs_shadow;
  logic             ofs_xfer;
  logic [INC_W-1:0] inc_shadow;
  logic             inc_xfer;
  logic [REG_W-1:0] run_ns;
  logic [SEC_W-1:0] run_sec;
  logic [REG_W-1:0] cap_ns_q;
  logic [SEC_W-1:0] cap_sec_q;

  ptp_req_ctrl u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_code  (req_code),
    .req_state (req_state),
    .cap_fire  (cap_fire),
    .zero_fire (zero_fire)
  );

  ptp_load_hs #(.DW(OFS_W)) u_ofs_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (ofs_wr),
    .data_i   ({ofs_sec_hi, ofs_sec_lo, ofs_ns}),
    .set_i    (ofs_load),
    .shadow_o (ofs_shadow),
    .xfer_o   (ofs_xfer),
    .busy_o   (ofs_busy)
  );

  ptp_load_hs #(.DW(INC_W)) u_inc_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (inc_wr),
    .data_i   (inc_val),
    .set_i    (inc_load),
    .shadow_o (inc_shadow),
    .xfer_o   (inc_xfer),
    .busy_o   (inc_busy)
  );

  ptp_time_acc #(
    .NS_WRAP (NS_WRAP),
    .INC_W   (INC_W),
    .FRAC_W  (FRAC_W),
    .DEF_INC (DEF_INC)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (zero_fire),
    .load_i     (ofs_xfer),
    .load_ns    (ofs_shadow[REG_W-1:0]),
    .load_sec   (ofs_shadow[OFS_W-1:REG_W]),
    .inc_xfer_i (inc_xfer),
    .inc_new    (inc_shadow),
    .ns_o       (run_ns),
    .sec_o      (run_sec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_ns_q  <= '0;
      cap_sec_q <= '0;
    end else if (cap_fire) begin
      cap_ns_q  <= run_ns;
      cap_sec_q <= run_sec;
    end
  end

  assign cap_ns     = cap_ns_q;
  assign cap_sec_lo = cap_sec_q[REG_W-1:0];
  assign cap_sec_hi = cap_sec_q[SEC_W-1:REG_W];

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> ($stable(cap_ns_q) && $stable(cap_sec_q))); // R5
  AST_CAP_TAKES_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (cap_sec_q == $past(run_sec) && cap_ns_q == $past(run_ns))); // R5

endmodule

// File: tb/ptp_time_counter_tb.sv
`timescale 1ns/1ps
module ptp_time_counter_tb;

  localparam int          WRAP = 1000;
  localparam logic [31:0] DEF  = 32'h0038_0000;
  localparam longint unsigned SEC_MASK = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [1:0]  req_code = 2'd0;
  logic [1:0]  req_state;
  logic        ofs_wr = 1'b0;
  logic [31:0] ofs_ns = '0;
  logic [31:0] ofs_sec_lo = '0;
  logic [15:0] ofs_sec_hi = '0;
  logic        ofs_load = 1'b0;
  logic        ofs_busy;
  logic        inc_wr = 1'b0;
  logic [31:0] inc_val = '0;
  logic        inc_load = 1'b0;
  logic        inc_busy;
  logic [31:0] cap_ns;
  logic [31:0] cap_sec_lo;
  logic [15:0] cap_sec_hi;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ptp_time_counter #(.NS_WRAP(WRAP), .DEF_INC(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_wr(req_wr), .req_code(req_code), .req_state(req_state),
    .ofs_wr(ofs_wr), .ofs_ns(ofs_ns), .ofs_sec_lo(ofs_sec_lo),
    .ofs_sec_hi(ofs_sec_hi), .ofs_load(ofs_load), .ofs_busy(ofs_busy),
    .inc_wr(inc_wr), .inc_val(inc_val), .inc_load(inc_load), .inc_busy(inc_busy),
    .cap_ns(cap_ns), .cap_sec_lo(cap_sec_lo), .cap_sec_hi(cap_sec_hi)
  );

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {sec[47:0], ns[31:0]} after 'units' (2^-20 ns) from a base with zero fraction.
  function automatic logic [79:0] expect_t(input longint unsigned bns,
                                           input longint unsigned bsec,
                                           input longint unsigned units);
    longint unsigned nst, sec, ns;
    nst = bns + (units >> 20);
    sec = (bsec + nst / WRAP) & SEC_MASK;
    ns  = nst % WRAP;
    return {sec[47:0], ns[31:0]};
  endfunction

  function automatic logic [79:0] cap_now();
    return {cap_sec_hi, cap_sec_lo, cap_ns};
  endfunction

  // All tasks start and end just after a falling edge.
  task automatic zero_req();
    req_wr = 1'b1; req_code = 2'd1;
    @(negedge clk);
    req_wr = 1'b0;
    chk("R4 zero shown", {78'd0, req_state}, 80'd1);
    @(negedge clk);
    chk("R4 field idle", {78'd0, req_state}, 80'd0);
  endtask

  task automatic capture();
    req_wr = 1'b1; req_code = 2'd2;
    @(negedge clk);
    req_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_inc(input logic [31:0] v);
    inc_wr = 1'b1; inc_val = v; inc_load = 1'b1;
    @(negedge clk);
    inc_wr = 1'b0; inc_load = 1'b0;
    chk("R8 busy set", {79'd0, inc_busy}, 80'd1);
    @(negedge clk);
    chk("R8 busy at xfer", {79'd0, inc_busy}, 80'd1);
    @(negedge clk);
    chk("R8 self clear", {79'd0, inc_busy}, 80'd0);
  endtask

  task automatic load_ofs(input logic [31:0] ns, input logic [47:0] sec);
    ofs_wr = 1'b1; ofs_ns = ns; ofs_sec_lo = sec[31:0]; ofs_sec_hi = sec[47:32];
    ofs_load = 1'b1;
    @(negedge clk);
    ofs_wr = 1'b0; ofs_load = 1'b0;
    chk("R7 busy set", {79'd0, ofs_busy}, 80'd1);
    @(negedge clk);
    chk("R7 busy at xfer", {79'd0, ofs_busy}, 80'd1);
    @(negedge clk);
    chk("R7 self clear", {79'd0, ofs_busy}, 80'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] incs [6];
    int          waits [6];
    logic [31:0] bns [4];
    logic [47:0] bsec [3];
    logic [79:0] held;
    incs  = '{32'h0010_0000, 32'h0014_0000, 32'h0038_0000,
              32'h0070_0001, 32'h003F_FFFF, 32'h0000_8000};
    waits = '{0, 1, 3, 64, 300, 999};
    bns   = '{32'd0, 32'd999, 32'd997, 32'd500};
    bsec  = '{48'd0, 48'h0000_FFFF_FFFF, 48'hFFFF_FFFF_FFFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 request idle", {78'd0, req_state}, 80'd0);
    chk("R1 busy low", {78'd0, ofs_busy, inc_busy}, 80'd0);
    chk("R1 capture zero", cap_now(), 80'd0);
    capture();
    chk("R1 default step from zero", cap_now(), expect_t(0, 0, DEF));

    // R2 R3 R6: step sweep after zeroing
    for (int i = 0; i < 6; i++) begin
      load_inc(incs[i]);
      for (int j = 0; j < 6; j++) begin
        zero_req();
        repeat (waits[j]) @(negedge clk);
        capture();
        chk("R2 R3 R6 step sweep", cap_now(),
            expect_t(0, 0, longint'(waits[j] + 1) * incs[i]));
      end
    end

    // R7 R3: preset sweep at wrap points
    load_inc(DEF);
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 3; b++) begin
        for (int m = 0; m < 4; m++) begin
          load_ofs(bns[a], bsec[b]);
          repeat (m * 3) @(negedge clk);
          capture();
          chk("R7 R3 preset sweep", cap_now(),
              expect_t(bns[a], bsec[b], longint'(m * 3 + 2) * DEF));
        end
      end
    end

    // R7 clamp of out-of-range nanoseconds
    load_ofs(32'd1005, 48'd7);
    capture();
    chk("R7 ns clamp", cap_now(), expect_t(999, 7, 2 * DEF));

    // R7 raise held while busy is ignored
    ofs_wr = 1'b1; ofs_ns = 32'd10; ofs_sec_lo = 32'd3; ofs_sec_hi = '0; ofs_load = 1'b1;
    @(negedge clk);
    ofs_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ofs_load = 1'b0;
    chk("R7 set while busy ignored", {79'd0, ofs_busy}, 80'd0);
    capture();
    chk("R7 no second load", cap_now(), expect_t(10, 3, 2 * DEF));

    // R8 old step used on transfer edge
    zero_req();
    inc_wr = 1'b1; inc_val = 32'h0014_0000; inc_load = 1'b1;
    @(negedge clk);
    inc_wr = 1'b0; inc_load = 1'b0;
    @(negedge clk);
    capture();
    chk("R8 old step on xfer edge", cap_now(),
        expect_t(0, 0, 2 * DEF + 64'h0014_0000));
    load_inc(DEF);

    // R4 R5: request while busy is dropped, capture value
    zero_req();
    req_wr = 1'b1; req_code = 2'd2;
    @(negedge clk);
    chk("R4 capture shown", {78'd0, req_state}, 80'd2);
    req_code = 2'd1;
    @(negedge clk);
    req_wr = 1'b0;
    chk("R4 busy write dropped", {78'd0, req_state}, 80'd0);
    chk("R5 capture value", cap_now(), expect_t(0, 0, DEF));
    capture();
    chk("R4 zeroing not applied", cap_now(), expect_t(0, 0, 3 * DEF));
    held = cap_now();
    repeat (10) @(negedge clk);
    chk("R5 capture holds", cap_now(), held);

    // R4 reserved code ignored
    req_wr = 1'b1; req_code = 2'd3;
    @(negedge clk);
    req_wr = 1'b0;
    chk("R4 code 3 ignored", {78'd0, req_state}, 80'd0);
    chk("R4 code 3 no capture", cap_now(), held);

    // R9 offset beats zeroing on the same edge
    req_wr = 1'b1; req_code = 2'd1;
    ofs_wr = 1'b1; ofs_ns = 32'd123; ofs_sec_lo = 32'd45; ofs_sec_hi = '0; ofs_load = 1'b1;
    @(negedge clk);
    req_wr = 1'b0; ofs_wr = 1'b0; ofs_load = 1'b0;
    @(negedge clk);
    capture();
    chk("R9 offset wins", cap_now(), expect_t(123, 45, DEF));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule